// File: doc/BRIEF.md
# I2C Bus Stall Watchdog and Stop Detector

This block sits beside an I2C controller and watches the two bus lines. It tracks whether the bus is between a start and a stop condition. While the bus is in that busy state, it measures how long SCL keeps the same level. If the bus stays stuck for a selectable number of counting ticks, the block raises a single-cycle timeout pulse and sets a sticky status bit.

Independently of the watchdog, it detects stop conditions. On a stop it sets an interrupt request bit, provided the stop interrupt is enabled. Software can clear either bit by writing zero to it.

Counting ticks come from an externally prescaled clock enable. That enable is divided further by a clock-select value, and the clock-select value is frozen while the surrounding interface is enabled. The counter is one register that wraps at either its full width (long window) or a narrower width (short window). The raw lines pass through a synchronizer before any edge is decoded.

Top module: `i2c_idle_guard`

## Requirements
- R1: A counting tick occurs on every (K+1)-th cycle with `tick_en` high, where K is the stored clock-select value. The stall counter never advances in a cycle without `tick_en`.
- R2: With the watchdog on and long mode selected (`cfg_wd_short`=0), `wd_pulse` is high for exactly one cycle once 2^LONG_W counting ticks have passed since the last restart.
- R3: With short mode selected (`cfg_wd_short`=1), the pulse comes after 2^SHORT_W counting ticks.
- R4: With the watchdog off (`cfg_wd_on`=0), no pulse occurs and `wd_status` is never set, whatever the mode bit holds.
- R5: The bus becomes busy when SDA falls while SCL is high (start), and idle when SDA rises while SCL is high (stop). The counter restarts from zero on every SCL edge, on a stop, and at any time the bus is idle, so an idle bus never times out.
- R6: `wd_status` is set on each timeout and holds. A write with `flag_wdata[1]`=0 clears it, and a write with `flag_wdata[1]`=1 leaves it unchanged. A timeout in the same cycle as a clearing write leaves it set.
- R7: A stop condition sets `stop_irq` only when `stop_ie` is 1. With `stop_ie`=0, a stop leaves it at 0.
- R8: A write with `flag_wdata[0]`=0 clears `stop_irq`, and a write with `flag_wdata[0]`=1 leaves it unchanged.
- R9: When a stop is detected in the same cycle as a clearing write, `stop_irq` ends up 1.
- R10: A configuration write always updates the on and mode bits. It updates the clock-select value only when `iface_en` is 0; otherwise the old value is kept.
- R11: After a synchronous reset, `wd_pulse`, `wd_status` and `stop_irq` are 0, and the synchronizers read both lines as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin | input | 1 | Raw SCL line level |
| sda_pin | input | 1 | Raw SDA line level |
| tick_en | input | 1 | Prescaled clock enable for the counter |
| iface_en | input | 1 | Interface enable; while high, clock-select writes are ignored |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wd_on | input | 1 | Watchdog on |
| cfg_wd_short | input | 1 | 1 = short window, 0 = long window |
| cfg_div_sel | input | SEL_W | Clock-select value K for tick division |
| stop_ie | input | 1 | Stop interrupt enable |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Bit 0 = stop flag, bit 1 = timeout status; 0 clears, 1 keeps |
| wd_pulse | output | 1 | One-cycle timeout event |
| wd_status | output | 1 | Sticky timeout status |
| stop_irq | output | 1 | Stop-condition interrupt request |

## Verification
The assertions assume that the raw lines are clean and that each level is held for longer than the synchronizer depth, so that every SCL or SDA change is seen exactly once. They also assume that SDA never changes in the same cycle as SCL. The stimulus changes only one line at a time, on the falling clock edge, with gaps of at least four cycles. It also keeps every deliberate stall within a single timeout window before it releases the bus. Strobes are one-cycle pulses driven synchronously, which matches the single-edge view the properties take.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;
  // width of the clock-select (tick divider) field
  parameter int unsigned SEL_W = 3;

  typedef struct packed {
    logic             wd_on;
    logic             wd_short;
    logic [SEL_W-1:0] div_sel;
  } guard_cfg_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_edge,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (stop_det)       busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
    end
  end

  // SCL must be high in both samples for a data transition to be a condition
  assign scl_edge  = scl_s ^ scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_stall_timer.sv
module i2c_stall_timer #(
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned SHORT_W = 14,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wd_on,
  input  logic             wd_short,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             restart,
  output logic             wrap,
  output logic             wd_pulse
);
  logic [SEL_W-1:0]  pre;
  logic [LONG_W-1:0] cnt;
  logic              step;
  logic              at_top;

  assign step   = tick_en && (pre == div_sel);
  assign at_top = wd_short ? (&cnt[SHORT_W-1:0]) : (&cnt);
  assign wrap   = wd_on && !restart && step && at_top;

  always_ff @(posedge clk) begin
    if (rst || !wd_on || restart) begin
      pre <= '0;
      cnt <= '0;
    end else if (tick_en) begin
      if (pre == div_sel) begin
        pre <= '0;
        cnt <= wrap ? '0 : cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wd_pulse <= 1'b0;
    else     wd_pulse <= wrap;
  end
endmodule

// File: rtl/i2c_idle_guard.sv
module i2c_idle_guard
  import i2c_guard_pkg::*;
#(
  parameter int unsigned LONG_W      = 16,
  parameter int unsigned SHORT_W     = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_pin,
  input  logic             sda_pin,
  input  logic             tick_en,
  input  logic             iface_en,
  input  logic             cfg_we,
  input  logic             cfg_wd_on,
  input  logic             cfg_wd_short,
  input  logic [SEL_W-1:0] cfg_div_sel,
  input  logic             stop_ie,
  input  logic             flag_we,
  input  logic [1:0]       flag_wdata,
  output logic             wd_pulse,
  output logic             wd_status,
  output logic             stop_irq
);
  localparam int unsigned FLAG_STOP = 0;
  localparam int unsigned FLAG_WD   = 1;

  guard_cfg_t       cfg_q;
  logic             wd_on_q;
  logic [SEL_W-1:0] div_sel_q;
  logic             scl_s, sda_s;
  logic             scl_edge, start_det, stop_det, busy;
  logic             restart, wrap;

  i2c_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_pin), .q(scl_s)
  );
  i2c_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_pin), .q(sda_s)
  );

  i2c_line_events u_events (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_edge(scl_edge), .start_det(start_det), .stop_det(stop_det), .busy(busy)
  );

  // configuration: divider field is locked while the interface runs
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.wd_on    <= cfg_wd_on;
      cfg_q.wd_short <= cfg_wd_short;
      if (!iface_en) cfg_q.div_sel <= cfg_div_sel;
    end
  end

  assign wd_on_q   = cfg_q.wd_on;
  assign div_sel_q = cfg_q.div_sel;
  assign restart   = scl_edge | stop_det | ~busy;

  i2c_stall_timer #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .SEL_W(SEL_W)) u_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .wd_on(cfg_q.wd_on), .wd_short(cfg_q.wd_short), .div_sel(cfg_q.div_sel),
    .restart(restart), .wrap(wrap), .wd_pulse(wd_pulse)
  );

  // flags: hardware set takes priority over a clearing write
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_status <= 1'b0;
      stop_irq  <= 1'b0;
    end else begin
      if (wrap)                                 wd_status <= 1'b1;
      else if (flag_we && !flag_wdata[FLAG_WD]) wd_status <= 1'b0;

      if (stop_det && stop_ie)                    stop_irq <= 1'b1;
      else if (flag_we && !flag_wdata[FLAG_STOP]) stop_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_idle_guard_chk.sv
module i2c_idle_guard_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             iface_en,
  input logic             stop_ie,
  input logic             flag_we,
  input logic [1:0]       flag_wdata,
  input logic             wd_pulse,
  input logic             wd_status,
  input logic             stop_irq,
  input logic             wd_on_q,
  input logic [SEL_W-1:0] div_sel_q,
  input logic             stop_seen
);
  p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    wd_pulse |=> !wd_pulse);

  p_off_no_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    !wd_on_q |=> !wd_pulse);

  p_pulse_sets_status_r6: assert property (@(posedge clk) disable iff (rst)
    wd_pulse |-> wd_status);

  p_stop_needs_ie_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_irq) |-> $past(stop_ie));

  p_stop_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !flag_wdata[0] && !stop_seen) |=> !stop_irq);

  p_sel_locked_r10: assert property (@(posedge clk) disable iff (rst)
    iface_en |=> $stable(div_sel_q));
endmodule

bind i2c_idle_guard i2c_idle_guard_chk #(.SEL_W(i2c_guard_pkg::SEL_W)) u_guard_chk (
  .clk(clk), .rst(rst), .iface_en(iface_en), .stop_ie(stop_ie),
  .flag_we(flag_we), .flag_wdata(flag_wdata), .wd_pulse(wd_pulse),
  .wd_status(wd_status), .stop_irq(stop_irq), .wd_on_q(wd_on_q),
  .div_sel_q(div_sel_q), .stop_seen(stop_det)
);

// File: tb/test_i2c_idle_guard.sv
`timescale 1ns/1ps
module test_i2c_idle_guard;
  localparam int unsigned LW = 6;
  localparam int unsigned SW = 4;
  localparam int unsigned SELW = i2c_guard_pkg::SEL_W;

  logic clk = 1'b0;
  logic rst;
  logic scl_pin, sda_pin, tick_en, iface_en;
  logic cfg_we, cfg_wd_on, cfg_wd_short;
  logic [SELW-1:0] cfg_div_sel;
  logic stop_ie, flag_we;
  logic [1:0] flag_wdata;
  logic wd_pulse, wd_status, stop_irq;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_idle_guard #(.LONG_W(LW), .SHORT_W(SW), .SYNC_STAGES(2)) i_i2c_idle_guard (
    .clk(clk), .rst(rst), .scl_pin(scl_pin), .sda_pin(sda_pin), .tick_en(tick_en),
    .iface_en(iface_en), .cfg_we(cfg_we), .cfg_wd_on(cfg_wd_on),
    .cfg_wd_short(cfg_wd_short), .cfg_div_sel(cfg_div_sel), .stop_ie(stop_ie),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .wd_pulse(wd_pulse),
    .wd_status(wd_status), .stop_irq(stop_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the expected cycle of every timeout pulse
  always @(negedge clk) begin
    if (!rst && wd_pulse) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R3 unexpected pulse actual=cycle %0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R2/R3 pulse timing actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  task automatic write_cfg(input logic on, input logic sh, input int sel);
    cfg_we = 1'b1; cfg_wd_on = on; cfg_wd_short = sh; cfg_div_sel = SELW'(sel);
    tick(1);
    cfg_we = 1'b0;
    tick(1);
  endtask

  task automatic write_flags(input logic [1:0] v);
    flag_we = 1'b1; flag_wdata = v;
    tick(1);
    flag_we = 1'b0;
    tick(1);
  endtask

  // start condition, then SCL low held; optionally expect a pulse
  task automatic stall(input int k, input int w, input bit expect_pulse, input int hold);
    sda_pin = 1'b0;
    tick(8);
    scl_pin = 1'b0;
    if (expect_pulse) exp_q.push_back(cyc + 3 + (k + 1) * (1 << w));
    tick(hold);
  endtask

  task automatic bus_stop();
    scl_pin = 1'b1;
    tick(4);
    sda_pin = 1'b1;
    tick(6);
  endtask

  initial begin
    rst = 1'b1; scl_pin = 1'b1; sda_pin = 1'b1; tick_en = 1'b1; iface_en = 1'b0;
    cfg_we = 1'b0; cfg_wd_on = 1'b0; cfg_wd_short = 1'b0; cfg_div_sel = '0;
    stop_ie = 1'b0; flag_we = 1'b0; flag_wdata = 2'b11;
    tick(5);
    chk("R11 wd_pulse after reset", int'(wd_pulse), 0);
    chk("R11 wd_status after reset", int'(wd_status), 0);
    chk("R11 stop_irq after reset", int'(stop_irq), 0);
    rst = 1'b0;
    tick(3);

    write_cfg(1'b1, 1'b0, 0);
    iface_en = 1'b1; stop_ie = 1'b1;
    tick(2);

    // R2 long window
    stall(0, LW, 1'b1, 72);
    chk("R2 long pulse seen", exp_q.size(), 0);
    chk("R6 status set", int'(wd_status), 1);
    write_flags(2'b11);
    chk("R6 write one keeps status", int'(wd_status), 1);
    write_flags(2'b01);
    chk("R6 write zero clears status", int'(wd_status), 0);
    bus_stop();
    chk("R7 stop sets flag", int'(stop_irq), 1);
    write_flags(2'b11);
    chk("R8 write one keeps stop flag", int'(stop_irq), 1);
    write_flags(2'b10);
    chk("R8 write zero clears stop flag", int'(stop_irq), 0);

    // R5 idle bus never times out
    tick(150);
    chk("R5 idle bus no status", int'(wd_status), 0);

    // R3 short window
    write_cfg(1'b1, 1'b1, 0);
    stall(0, SW, 1'b1, 24);
    chk("R3 short pulse seen", exp_q.size(), 0);
    bus_stop();
    write_flags(2'b00);

    // R10 divider write ignored while interface enabled
    write_cfg(1'b1, 1'b1, 3);
    stall(0, SW, 1'b1, 24);
    chk("R10 locked divider kept", exp_q.size(), 0);
    bus_stop();
    write_flags(2'b00);
    iface_en = 1'b0;
    write_cfg(1'b1, 1'b1, 1);
    iface_en = 1'b1;
    tick(2);
    stall(1, SW, 1'b1, 40);
    chk("R10 R1 divider by two accepted", exp_q.size(), 0);
    bus_stop();
    write_flags(2'b00);

    // R1 no counting without tick_en
    tick_en = 1'b0;
    stall(1, SW, 1'b0, 90);
    chk("R1 no tick no status", int'(wd_status), 0);
    bus_stop();
    tick_en = 1'b1;
    write_flags(2'b00);

    // R4 watchdog off
    write_cfg(1'b0, 1'b1, 1);
    stall(0, SW, 1'b0, 90);
    chk("R4 off no status", int'(wd_status), 0);
    bus_stop();
    write_flags(2'b00);

    // R5 SCL toggling restarts the counter (window 32 cycles)
    write_cfg(1'b1, 1'b1, 1);
    sda_pin = 1'b0;
    tick(8);
    for (int i = 0; i < 10; i++) begin
      scl_pin = ~scl_pin;
      tick(12);
    end
    chk("R5 edges restart counter", int'(wd_status), 0);
    bus_stop();
    write_flags(2'b00);

    // R7 stop ignored with interrupt disabled
    stop_ie = 1'b0;
    sda_pin = 1'b0;
    tick(8);
    sda_pin = 1'b1;
    tick(6);
    chk("R7 disabled stop no flag", int'(stop_irq), 0);
    stop_ie = 1'b1;

    // R9 hardware set beats clearing write in the same cycle
    sda_pin = 1'b0;
    tick(8);
    sda_pin = 1'b1;
    tick(2);
    flag_we = 1'b1; flag_wdata = 2'b10;
    tick(1);
    flag_we = 1'b0;
    chk("R9 set wins over clear", int'(stop_irq), 1);
    tick(3);
    write_flags(2'b10);
    chk("R8 cleared after set-wins", int'(stop_irq), 0);

    tick(10);
    chk("R2 no pending pulses", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule